// File: doc/BRIEF.md
# Hardware Page Table Walker

This engine turns a 32-bit virtual address into a physical address by reading translation descriptors out of memory. A request supplies the virtual address, the current context number and the base of the context table. The walker first reads the context entry, then descends through up to three indexed tables. Each table is located through the descriptor fetched before it. A leaf may turn up at any of these four stops. The level where it is found sets how many low virtual-address bits pass straight through as the page offset.

Descriptors are fetched over a simple read port that allows one outstanding read at a time. The address is held until the memory accepts it, and the data returns later with an error flag. Each accepted request yields exactly one response. The response holds a hit or fault flag, the composed physical address, the level where the walk stopped, the raw leaf descriptor and the page base taken from it. The walker is meant to sit behind a translation cache and serve its misses. It takes a new request only while it is idle.

Top module: `ptw_engine`

## Requirements
- R1: A request whose context table base is zero faults at level 0 with no memory read, and the response appears in the cycle after the request is accepted.
- R2: The first read of a walk goes to context table base + 4 × context number.
- R3: A descriptor's type is its bits [1:0]: 0 is invalid, 1 is a table pointer, 2 is a leaf, 3 is reserved. Types 0 and 3 end the walk with a fault that reports the level of that descriptor.
- R4: After a table pointer, the next read goes to ((descriptor with bits [3:0] cleared) << 4) + 4 × index, truncated to 32 bits. The index for table levels 1, 2 and 3 is virtual address bits [31:24], [23:18] and [17:12].
- R5: A table pointer found at level 3 ends the walk with a fault, so a walk makes at most four reads.
- R6: A leaf in the context entry gives level 0, and the physical address equals the virtual address.
- R7: A leaf at table level n (1, 2 or 3) gives level n. The physical address is the virtual address bits below bit 24, 18 or 12 ORed with ((leaf with bits [7:0] cleared) << 4).
- R8: On a hit, the response carries the leaf as it was read and the page base (the leaf with bits [7:0] cleared). On any fault, the physical address and page base are zero. The leaf field then holds the offending descriptor, or zero when no descriptor was classified.
- R9: A read returned with the error flag ends the walk with a fault at the level of that read (0 for the context entry).
- R10: A request is accepted only in a cycle where `req_ready` is high, and `req_ready` is high only while idle. Requests offered during a walk are ignored.
- R11: `rsp_valid` is high for exactly one cycle per accepted request.
- R12: A read request keeps its address stable until `mem_req_ready` accepts it. No new read is issued until the data of the previous one has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | 8 | Context number |
| req_ctx_base | input | 32 | Context table base address |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor value |
| mem_rsp_err | input | 1 | Read failed |
| rsp_valid | output | 1 | Walk result, one cycle |
| rsp_fault | output | 1 | Walk failed |
| rsp_level | output | 2 | Level where the walk ended |
| rsp_paddr | output | 32 | Composed physical address |
| rsp_pte | output | 32 | Leaf or offending descriptor |
| rsp_page_base | output | 32 | Leaf with low 8 bits cleared |

## Verification
The assertions check the handshake rules on every cycle. They cover the single-cycle response pulse, the held read address, the single outstanding read, the zero-base shortcut, the address of the first read, pass-through of a context-level leaf, and zeroed addresses on faults. The bench's scenarios are the only evidence for the path through memory. They cover the index fields chosen at each level, the table-base arithmetic, the offset width per level, the fault level for each descriptor type and for read errors, and the exact number of reads per walk. These are compared against a reference walk over a sparse memory model that stalls reads now and then.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // descriptor type field, bits [1:0]
  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_TABLE   = 2'd1,
    ET_LEAF    = 2'd2,
    ET_RSVD    = 2'd3
  } etype_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_DECODE,
    ST_DONE
  } wstate_e;

  localparam logic [1:0] LVL_CTX  = 2'd0;
  localparam logic [1:0] LVL_LAST = 2'd3;

endpackage

// File: rtl/ptw_desc_class.sv
module ptw_desc_class
  import ptw_pkg::*;
#(
  parameter int DESC_W = 32
) (
  input  logic [DESC_W-1:0] desc,
  output etype_e            etype,
  output logic              is_table,
  output logic              is_leaf
);

  always_comb begin
    etype    = etype_e'(desc[1:0]);
    is_table = (etype == ET_TABLE);
    is_leaf  = (etype == ET_LEAF);
  end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int CTX_W     = 8,
  parameter int SH1       = 24,
  parameter int SH2       = 18,
  parameter int SH3       = 12,
  parameter int PTD_SHIFT = 4
) (
  input  logic [ADDR_W-1:0] ctx_base,
  input  logic [CTX_W-1:0]  ctx,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] desc,
  input  logic [1:0]        tbl_level,
  output logic [ADDR_W-1:0] ctx_addr,
  output logic [ADDR_W-1:0] next_addr
);

  localparam int ENTRY_SH = 2;
  localparam logic [ADDR_W-1:0] PTD_LOW = (ADDR_W'(1) << PTD_SHIFT) - ADDR_W'(1);

  logic [ADDR_W-1:0] idx;
  logic [ADDR_W-1:0] tbl_base;

  always_comb begin
    case (tbl_level)
      2'd1:    idx = ADDR_W'(vaddr[ADDR_W-1:SH1]);
      2'd2:    idx = ADDR_W'(vaddr[SH1-1:SH2]);
      2'd3:    idx = ADDR_W'(vaddr[SH2-1:SH3]);
      default: idx = '0;
    endcase
    tbl_base  = (desc & ~PTD_LOW) << PTD_SHIFT;
    next_addr = tbl_base + (idx << ENTRY_SH);
    ctx_addr  = ctx_base + (ADDR_W'(ctx) << ENTRY_SH);
  end

endmodule

// File: rtl/ptw_phys_compose.sv
module ptw_phys_compose #(
  parameter int ADDR_W    = 32,
  parameter int SH1       = 24,
  parameter int SH2       = 18,
  parameter int SH3       = 12,
  parameter int PTD_SHIFT = 4,
  parameter int PPN_LO    = 8
) (
  input  logic [1:0]        level,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] pte,
  output logic [ADDR_W-1:0] paddr,
  output logic [ADDR_W-1:0] page_base
);

  localparam logic [ADDR_W-1:0] PPN_MASK = ~((ADDR_W'(1) << PPN_LO) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] OFF1 = (ADDR_W'(1) << SH1) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF2 = (ADDR_W'(1) << SH2) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF3 = (ADDR_W'(1) << SH3) - ADDR_W'(1);

  logic [ADDR_W-1:0] hi;

  always_comb begin
    page_base = pte & PPN_MASK;
    hi        = page_base << PTD_SHIFT;
    case (level)
      2'd1:    paddr = (vaddr & OFF1) | hi;
      2'd2:    paddr = (vaddr & OFF2) | hi;
      2'd3:    paddr = (vaddr & OFF3) | hi;
      default: paddr = vaddr;
    endcase
  end

endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CTX_W     = 8,
  parameter int IDX1_W    = 8,
  parameter int IDX2_W    = 6,
  parameter int IDX3_W    = 6,
  parameter int PTD_SHIFT = 4,
  parameter int PPN_LO    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [ADDR_W-1:0] req_ctx_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [1:0]        rsp_level,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ADDR_W-1:0] rsp_pte,
  output logic [ADDR_W-1:0] rsp_page_base
);

  localparam int SH3 = ADDR_W - IDX1_W - IDX2_W - IDX3_W;
  localparam int SH2 = SH3 + IDX3_W;
  localparam int SH1 = SH2 + IDX2_W;

  wstate_e           state, st_n;
  logic [1:0]        lvl_q;
  logic [ADDR_W-1:0] va_q, addr_q, desc_q;
  logic              err_q;

  etype_e            etype;
  logic              is_table, is_leaf;
  logic [ADDR_W-1:0] ctx_addr, next_addr, cmp_paddr, cmp_pbase;

  logic              done_now, done_fault, advance;
  logic [1:0]        done_level;
  logic [ADDR_W-1:0] done_paddr, done_pte, done_pbase;

  ptw_desc_class #(.DESC_W(ADDR_W)) u_class (
    .desc     (desc_q),
    .etype    (etype),
    .is_table (is_table),
    .is_leaf  (is_leaf)
  );

  ptw_addr_gen #(
    .ADDR_W(ADDR_W), .CTX_W(CTX_W), .SH1(SH1), .SH2(SH2), .SH3(SH3),
    .PTD_SHIFT(PTD_SHIFT)
  ) u_addr (
    .ctx_base  (req_ctx_base),
    .ctx       (req_ctx),
    .vaddr     (va_q),
    .desc      (desc_q),
    .tbl_level (lvl_q + 2'd1),
    .ctx_addr  (ctx_addr),
    .next_addr (next_addr)
  );

  ptw_phys_compose #(
    .ADDR_W(ADDR_W), .SH1(SH1), .SH2(SH2), .SH3(SH3),
    .PTD_SHIFT(PTD_SHIFT), .PPN_LO(PPN_LO)
  ) u_comp (
    .level     (lvl_q),
    .vaddr     (va_q),
    .pte       (desc_q),
    .paddr     (cmp_paddr),
    .page_base (cmp_pbase)
  );

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_FETCH);
  assign mem_req_addr  = addr_q;

  // next state and walk outcome
  always_comb begin
    st_n       = state;
    done_now   = 1'b0;
    done_fault = 1'b1;
    done_level = LVL_CTX;
    done_paddr = '0;
    done_pte   = '0;
    done_pbase = '0;
    advance    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_ctx_base == '0) begin
            done_now = 1'b1;
            st_n     = ST_DONE;
          end else begin
            st_n = ST_FETCH;
          end
        end
      end
      ST_FETCH: if (mem_req_ready) st_n = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) st_n = ST_DECODE;
      ST_DECODE: begin
        st_n       = ST_DONE;
        done_now   = 1'b1;
        done_level = lvl_q;
        if (!err_q) begin
          done_pte = desc_q;
          if (is_leaf) begin
            done_fault = 1'b0;
            done_paddr = cmp_paddr;
            done_pbase = cmp_pbase;
          end else if (is_table && lvl_q != LVL_LAST) begin
            advance  = 1'b1;
            done_now = 1'b0;
            st_n     = ST_FETCH;
          end
        end
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      lvl_q         <= LVL_CTX;
      va_q          <= '0;
      addr_q        <= '0;
      desc_q        <= '0;
      err_q         <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_level     <= LVL_CTX;
      rsp_paddr     <= '0;
      rsp_pte       <= '0;
      rsp_page_base <= '0;
    end else begin
      state     <= st_n;
      rsp_valid <= done_now;
      if (done_now) begin
        rsp_fault     <= done_fault;
        rsp_level     <= done_level;
        rsp_paddr     <= done_paddr;
        rsp_pte       <= done_pte;
        rsp_page_base <= done_pbase;
      end
      if (state == ST_IDLE && req_valid) begin
        va_q   <= req_vaddr;
        lvl_q  <= LVL_CTX;
        addr_q <= ctx_addr;
      end
      if (state == ST_WAIT && mem_rsp_valid) begin
        desc_q <= mem_rsp_data;
        err_q  <= mem_rsp_err;
      end
      if (advance) begin
        addr_q <= next_addr;
        lvl_q  <= lvl_q + 2'd1;
      end
    end
  end

  AST_ZERO_BASE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_ctx_base == '0) |=> (rsp_valid && rsp_fault && !mem_req_valid)); // R1

  AST_CTX_ADDR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_ctx_base != '0) |=>
      (mem_req_valid && mem_req_addr == $past(req_ctx_base) + (ADDR_W'($past(req_ctx)) << 2))); // R2

  AST_CTX_PASS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault && rsp_level == LVL_CTX) |-> (rsp_paddr == va_q)); // R6

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_page_base == '0)); // R8

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R11

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R12

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R12

endmodule

// File: tb/ptw_engine_test.sv
`timescale 1ns/1ps
module ptw_engine_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_ctx = '0;
  logic [31:0] req_ctx_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_level;
  logic [31:0] rsp_paddr, rsp_pte, rsp_page_base;

  always #4 clk = ~clk;

  ptw_engine uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_ctx(req_ctx), .req_ctx_base(req_ctx_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
    .rsp_paddr(rsp_paddr), .rsp_pte(rsp_pte), .rsp_page_base(rsp_page_base)
  );

  typedef struct {
    string       tag;
    logic        fault;
    logic [1:0]  level;
    logic [31:0] paddr;
    logic [31:0] pte;
    logic [31:0] pbase;
    int          reads;
    int          start;
  } exp_t;

  logic [31:0] mem [logic [31:0]];
  bit          errs [logic [31:0]];
  exp_t        sbq [$];
  int          checks = 0, fails = 0, reads = 0, overlap = 0;
  bit          done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference walk written from the requirements
  function automatic exp_t ref_walk(logic [31:0] va, logic [7:0] ctx, logic [31:0] base);
    exp_t e;
    logic [31:0] a, d, idx;
    int sh;
    e.fault = 1; e.level = 0; e.paddr = 0; e.pte = 0; e.pbase = 0; e.reads = 0;
    if (base == 0) return e;
    a = base + {22'b0, ctx, 2'b00};
    for (int lv = 0; lv < 4; lv++) begin
      e.reads++;
      e.level = lv[1:0];
      if (errs.exists(a)) begin e.pte = 0; return e; end
      d = mem.exists(a) ? mem[a] : 32'h0;
      if (d[1:0] == 2'd2) begin
        e.fault = 0; e.pte = d; e.pbase = d & 32'hFFFF_FF00;
        sh = (lv == 1) ? 24 : (lv == 2) ? 18 : 12;
        e.paddr = (lv == 0) ? va : ((va & ((32'h1 << sh) - 1)) | (e.pbase << 4));
        return e;
      end
      if (d[1:0] == 2'd1 && lv < 3) begin
        idx = (lv == 0) ? {24'b0, va[31:24]} : (lv == 1) ? {26'b0, va[23:18]} : {26'b0, va[17:12]};
        a = ((d & 32'hFFFF_FFF0) << 4) + (idx << 2);
      end else begin
        e.pte = d;
        return e;
      end
    end
    return e;
  endfunction

  function automatic logic [31:0] ptd(logic [31:0] t);
    return (t >> 4) | 32'h1;
  endfunction

  function automatic logic [31:0] pte(logic [31:0] p);
    return ((p >> 4) & 32'hFFFF_FF00) | 32'hE6;
  endfunction

  function automatic logic [31:0] mkva(int i1, int i2, int i3, int off);
    return {i1[7:0], i2[5:0], i3[5:0], off[11:0]};
  endfunction

  // memory responder: one-cycle latency, periodic stalls
  initial begin
    logic [31:0] pa;
    bit pend, outst;
    int cyc;
    pend = 0; outst = 0; cyc = 0; pa = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (mem_rsp_valid) outst = 0;
      if (!rst && mem_req_valid && outst) overlap++;
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      if (pend) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_err   <= errs.exists(pa);
        mem_rsp_data  <= mem.exists(pa) ? mem[pa] : 32'h0;
        pend = 0;
      end
      if (!rst && mem_req_valid && mem_req_ready) begin
        pend = 1; outst = 1; pa = mem_req_addr; reads++;
      end
      mem_req_ready <= (cyc % 4 != 1);
    end
  end

  // monitor: pops expected items as results appear
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        if (sbq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R10 unexpected response: actual 1 expected 0");
        end else begin
          e = sbq.pop_front();
          chk(e.tag, "fault", {31'b0, rsp_fault}, {31'b0, e.fault});
          chk(e.tag, "level", {30'b0, rsp_level}, {30'b0, e.level});
          chk(e.tag, "paddr", rsp_paddr, e.paddr);
          chk("R8", "pte", rsp_pte, e.pte);
          chk("R8", "page_base", rsp_page_base, e.pbase);
          chk(e.tag, "reads", reads - e.start, e.reads);
          @(negedge clk);
          chk("R11", "pulse", {31'b0, rsp_valid}, 32'h0);
        end
      end
    end
  end

  task automatic run(string tag, logic [31:0] va, logic [7:0] ctx, logic [31:0] base, bit garbage);
    exp_t e;
    e = ref_walk(va, ctx, base);
    e.tag = tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.start = reads;
    sbq.push_back(e);
    req_valid = 1; req_vaddr = va; req_ctx = ctx; req_ctx_base = base;
    @(negedge clk);
    if (garbage) begin
      req_vaddr = ~va; req_ctx = ctx + 8'd1;
      repeat (3) @(negedge clk);
    end
    req_valid = 0;
    while (sbq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  localparam logic [31:0] CB  = 32'h0000_1000;
  localparam logic [31:0] T1A = 32'h0002_0000;
  localparam logic [31:0] T1B = 32'h0003_0000;
  localparam logic [31:0] T2  = 32'h0004_0000;
  localparam logic [31:0] T3  = 32'h0005_0000;
  localparam logic [31:0] T3B = 32'h0006_0000;

  initial begin
    mem[CB + 32'd12]        = ptd(T1A);
    mem[T1A + 32'h12 * 4]   = pte(32'h8765_4000);
    mem[CB + 32'd20]        = pte(32'h1234_5000);
    mem[CB + 32'd28]        = ptd(T1B);
    mem[T1B + 32'hA5 * 4]   = ptd(T2);
    mem[T1B + 32'hA6 * 4]   = 32'h0000_0003;
    mem[T2 + 32'h11 * 4]    = pte(32'hCAFE_0000);
    mem[T2 + 32'h22 * 4]    = ptd(T3);
    mem[T3 + 32'h05 * 4]    = pte(32'h0BAD_F000);
    mem[T3 + 32'h06 * 4]    = ptd(T3B);
    mem[T3 + 32'h07 * 4]    = 32'h0000_0003;
    errs[T2 + 32'h33 * 4]   = 1;
    errs[CB + 32'd36]       = 1;

    repeat (4) @(negedge clk);
    chk("R10", "ready in reset", {31'b0, req_ready}, 32'h1);
    chk("R11", "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    chk("R12", "mem_req_valid in reset", {31'b0, mem_req_valid}, 32'h0);
    rst = 0;
    @(negedge clk);

    run("R1", 32'hDEAD_BEEF, 8'd3, 32'h0, 0);
    run("R2", 32'h0000_0ABC, 8'd5, CB, 0);
    run("R6", 32'h7654_3210, 8'd5, CB, 0);
    run("R7", mkva(8'h12, 6'h2A, 6'h15, 12'h345), 8'd3, CB, 0);
    run("R7", mkva(8'h12, 6'h01, 6'h3F, 12'hFFF), 8'd3, CB, 0);
    run("R4", mkva(8'hA5, 6'h11, 6'h2C, 12'h123), 8'd7, CB, 0);
    run("R7", mkva(8'hA5, 6'h22, 6'h05, 12'h9AB), 8'd7, CB, 0);
    run("R5", mkva(8'hA5, 6'h22, 6'h06, 12'h001), 8'd7, CB, 0);
    run("R3", mkva(8'hA5, 6'h22, 6'h07, 12'h002), 8'd7, CB, 0);
    run("R3", mkva(8'hA5, 6'h22, 6'h08, 12'h003), 8'd7, CB, 0);
    run("R3", mkva(8'hA6, 6'h00, 6'h00, 12'h004), 8'd7, CB, 0);
    run("R3", 32'h1111_2222, 8'd11, CB, 0);
    run("R9", mkva(8'hA5, 6'h33, 6'h01, 12'h005), 8'd7, CB, 0);
    run("R9", 32'h4444_5555, 8'd9, CB, 0);
    run("R10", mkva(8'hA5, 6'h22, 6'h05, 12'h777), 8'd7, CB, 1);
    run("R1", 32'h0000_0001, 8'd255, 32'h0, 0);

    repeat (20) @(negedge clk);
    chk("R10", "leftover expected items", sbq.size(), 32'h0);
    chk("R12", "reads issued while one outstanding", overlap, 32'h0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule